// File: doc/BRIEF.md
# Rename Table with Branch Snapshots

This block is the register alias table of an out-of-order core. It maps each architectural register either to the committed architectural file or to a physical tag. Renamed instructions read their source mappings through two lookup ports and record a new destination mapping through one write port. The live table always reflects the most recently renamed instruction, wrong-path ones included.

Each renamed branch asks for a snapshot slot from a small pool. When one is granted, the whole mapping is copied into that slot and the slot number goes back to the branch. When the branch resolves correctly, its slot is released and the live table is left alone. When it mispredicts, the live table is reloaded from that branch's snapshot in one cycle. The same cycle also releases the branch's own slot and every slot taken by a younger branch, so renaming resumes on the next cycle. A commit-side clear input supports the simpler drain-based recovery. Once the pipeline has drained, it points every entry back at the architectural file and empties the pool.

Top module: `rename_ckpt_table`

## Requirements
- R1: After reset, every entry reads as architectural-file (phys flag 0, tag 0) and all snapshot slots are free.
- R2: A destination write of tag T to register r (dst_en=1) makes later lookups of r return phys flag 1 and tag T from the next cycle on.
- R3: A branch request with a free slot and no restore or clear in the same cycle is granted the lowest-numbered free slot, and br_ckpt_id shows that slot number.
- R4: A branch request when no slot is free, or in a restore or clear cycle, is not granted and raises br_stall; the request may be repeated.
- R5: A correct resolve (res_valid=1, res_mispredict=0) of a held slot frees that slot and leaves the live table unchanged.
- R6: A mispredict resolve of a held slot reloads the whole live table from that slot's snapshot by the next cycle.
- R7: A mispredict frees the resolved slot and every slot granted after it. Slots granted before it stay held, and their snapshots stay intact.
- R8: In a mispredict-restore cycle, the destination write and any branch grant are dropped.
- R9: arch_clear sets every entry to architectural-file and frees every slot by the next cycle. It takes priority over restore, write and grant.
- R10: A resolve that names a slot not currently held has no effect on the table or the pool.
- R11: The snapshot of a branch granted in the same cycle as a destination write includes that write.
- R12: Lookups show the table as it stood before the current cycle's write; there is no same-cycle bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src0_idx | input | 4 | Architectural register looked up on port 0 |
| src0_phys | output | 1 | 1 when port 0's register maps to a physical tag |
| src0_tag | output | 5 | Physical tag for port 0 (0 when architectural) |
| src1_idx | input | 4 | Architectural register looked up on port 1 |
| src1_phys | output | 1 | 1 when port 1's register maps to a physical tag |
| src1_tag | output | 5 | Physical tag for port 1 (0 when architectural) |
| dst_en | input | 1 | Destination mapping write enable |
| dst_idx | input | 4 | Architectural register being written |
| dst_tag | input | 5 | New physical tag |
| br_req | input | 1 | A branch is being renamed this cycle |
| br_grant | output | 1 | Snapshot slot granted to the branch |
| br_ckpt_id | output | 2 | Granted slot number |
| br_stall | output | 1 | Branch request could not be granted |
| res_valid | input | 1 | A branch resolves this cycle |
| res_mispredict | input | 1 | 1 = mispredicted, 0 = correct |
| res_ckpt_id | input | 2 | Slot of the resolving branch |
| arch_clear | input | 1 | Point all entries at the architectural file and free all slots |

## Verification
The assertions check the pool's bookkeeping on every cycle. They cover the stall when the pool is full and the grant when it is not, the priority of clear and restore over write and grant, and the release of a resolved slot. They also check that a write is visible on the next lookup and that a clear leaves the pool empty. Whether a restore brings back exactly the right mapping for all sixteen registers can only be shown by the bench. The same holds for which younger slots a mispredict releases and whether the surviving older snapshots are still intact. The bench compares every lookup and grant against its own age-ordered model, and it reads the whole table after each directed recovery.

// File: rtl/rct_pkg.sv
package rct_pkg;
  // index of the lowest set bit; 0 when none
  function automatic int unsigned lowest_set(input logic [31:0] m);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  // entry layout: {phys_flag, tag}; all zero means architectural file
  function automatic logic is_phys(input logic [31:0] ent, input int unsigned tag_w);
    return ent[tag_w];
  endfunction
endpackage

// File: rtl/rct_slot_pool.sv
module rct_slot_pool #(
  parameter int NCK = 4,
  localparam int CW = (NCK > 1) ? $clog2(NCK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          flush_all,
  input  logic          res_valid,
  input  logic          res_bad,
  input  logic [CW-1:0] res_id,
  output logic          alloc_ok,
  output logic [CW-1:0] alloc_id,
  output logic          restore_go,
  output logic          release_go,
  output logic [NCK-1:0] live_o
);
  import rct_pkg::*;

  logic [NCK-1:0] live;
  logic [NCK-1:0] younger [NCK];
  logic [NCK-1:0] drop;
  logic           any_free;
  logic           hit;

  assign any_free   = ~&live;
  assign hit        = live[res_id];
  assign restore_go = res_valid && res_bad && hit && !flush_all;
  assign release_go = res_valid && !res_bad && hit && !flush_all;
  assign alloc_id   = CW'(lowest_set(32'(~live)));
  assign alloc_ok   = alloc_req && any_free && !flush_all && !restore_go;
  assign live_o     = live;

  always_comb begin
    drop = '0;
    if (flush_all)       drop = '1;
    else if (restore_go) drop = younger[res_id] | (NCK'(1) << res_id);
    else if (release_go) drop = NCK'(1) << res_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      for (int j = 0; j < NCK; j++) younger[j] <= '0;
    end else begin
      live <= (live & ~drop) | (alloc_ok ? (NCK'(1) << alloc_id) : '0);
      for (int j = 0; j < NCK; j++) begin
        if (alloc_ok && CW'(j) == alloc_id)
          younger[j] <= '0;
        else if (alloc_ok && live[j] && !drop[j])
          younger[j] <= (younger[j] & ~drop) | (NCK'(1) << alloc_id);
        else
          younger[j] <= younger[j] & ~drop;
      end
    end
  end
endmodule

// File: rtl/rct_map_store.sv
module rct_map_store #(
  parameter int NAR = 16,
  parameter int NPT = 32,
  parameter int NCK = 4,
  parameter int NRD = 2,
  localparam int AW = $clog2(NAR),
  localparam int TW = $clog2(NPT),
  localparam int EW = TW + 1,
  localparam int CW = (NCK > 1) ? $clog2(NCK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0][AW-1:0] rd_idx,
  output logic [NRD-1:0][EW-1:0] rd_ent,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_idx,
  input  logic [TW-1:0]          wr_tag,
  input  logic                   clear_all,
  input  logic                   restore_en,
  input  logic [CW-1:0]          restore_id,
  input  logic                   snap_en,
  input  logic [CW-1:0]          snap_id
);
  logic [EW-1:0] map_q  [NAR];
  logic [EW-1:0] map_d  [NAR];
  logic [EW-1:0] snap_q [NCK][NAR];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_ent[p] = map_q[rd_idx[p]];
  end

  always_comb begin
    for (int r = 0; r < NAR; r++) begin
      if (clear_all)       map_d[r] = '0;
      else if (restore_en) map_d[r] = snap_q[restore_id][r];
      else if (wr_en && AW'(r) == wr_idx) map_d[r] = {1'b1, wr_tag};
      else                 map_d[r] = map_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NAR; r++) map_q[r] <= '0;
    end else begin
      for (int r = 0; r < NAR; r++) map_q[r] <= map_d[r];
    end
  end

  always_ff @(posedge clk) begin
    if (snap_en) begin
      for (int r = 0; r < NAR; r++) snap_q[snap_id][r] <= map_d[r];
    end
  end
endmodule

// File: rtl/rename_ckpt_table.sv
module rename_ckpt_table #(
  parameter int NAR = 16,
  parameter int NPT = 32,
  parameter int NCK = 4,
  localparam int AW = $clog2(NAR),
  localparam int TW = $clog2(NPT),
  localparam int EW = TW + 1,
  localparam int CW = (NCK > 1) ? $clog2(NCK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src0_idx,
  output logic          src0_phys,
  output logic [TW-1:0] src0_tag,
  input  logic [AW-1:0] src1_idx,
  output logic          src1_phys,
  output logic [TW-1:0] src1_tag,
  input  logic          dst_en,
  input  logic [AW-1:0] dst_idx,
  input  logic [TW-1:0] dst_tag,
  input  logic          br_req,
  output logic          br_grant,
  output logic [CW-1:0] br_ckpt_id,
  output logic          br_stall,
  input  logic          res_valid,
  input  logic          res_mispredict,
  input  logic [CW-1:0] res_ckpt_id,
  input  logic          arch_clear
);
  // named internal events (used by the bound checker)
  logic           restore_go;
  logic           release_go;
  logic           write_go;
  logic [NCK-1:0] slot_live;
  logic [1:0][AW-1:0] rd_idx;
  logic [1:0][EW-1:0] rd_ent;

  rct_slot_pool #(.NCK(NCK)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(br_req), .flush_all(arch_clear),
    .res_valid(res_valid), .res_bad(res_mispredict), .res_id(res_ckpt_id),
    .alloc_ok(br_grant), .alloc_id(br_ckpt_id),
    .restore_go(restore_go), .release_go(release_go), .live_o(slot_live)
  );

  assign write_go = dst_en && !arch_clear && !restore_go;
  assign br_stall = br_req && !br_grant;
  assign rd_idx   = {src1_idx, src0_idx};

  rct_map_store #(.NAR(NAR), .NPT(NPT), .NCK(NCK), .NRD(2)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_ent(rd_ent),
    .wr_en(write_go), .wr_idx(dst_idx), .wr_tag(dst_tag),
    .clear_all(arch_clear),
    .restore_en(restore_go), .restore_id(res_ckpt_id),
    .snap_en(br_grant), .snap_id(br_ckpt_id)
  );

  assign src0_phys = rd_ent[0][TW];
  assign src0_tag  = rd_ent[0][TW-1:0];
  assign src1_phys = rd_ent[1][TW];
  assign src1_tag  = rd_ent[1][TW-1:0];
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
  parameter int AW = 4,
  parameter int TW = 5,
  parameter int CW = 2,
  parameter int NCK = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] src0_idx,
  input logic          src0_phys,
  input logic [TW-1:0] src0_tag,
  input logic [AW-1:0] dst_idx,
  input logic [TW-1:0] dst_tag,
  input logic          br_req,
  input logic          br_grant,
  input logic          br_stall,
  input logic [CW-1:0] res_ckpt_id,
  input logic          arch_clear,
  input logic          restore_go,
  input logic          release_go,
  input logic          write_go,
  input logic [NCK-1:0] slot_live
);
  // R2: a write is seen by the next lookup of the same register
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    write_go |=> (src0_idx != $past(dst_idx)) || (src0_phys && src0_tag == $past(dst_tag)));

  // R3: free slot and no priority event means a grant
  assert_grant_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && !(&slot_live) && !arch_clear && !restore_go) |-> br_grant);

  // R4: full pool stalls
  assert_stall_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && (&slot_live)) |-> (br_stall && !br_grant));

  // R5: correct resolve releases the slot
  assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_go |=> !slot_live[$past(res_ckpt_id)]);

  // R7: mispredict releases its own slot
  assert_restore_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_go |=> !slot_live[$past(res_ckpt_id)]);

  // R8: restore blocks rename
  assert_restore_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_go |-> (!br_grant && !write_go));

  // R9: clear empties the pool and blocks everything else
  assert_clear_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arch_clear |-> (!br_grant && !write_go && !restore_go));
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arch_clear |=> (slot_live == '0));
endmodule

bind rename_ckpt_table rct_checker #(.AW(AW), .TW(TW), .CW(CW), .NCK(NCK)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .src0_idx(src0_idx), .src0_phys(src0_phys), .src0_tag(src0_tag),
  .dst_idx(dst_idx), .dst_tag(dst_tag),
  .br_req(br_req), .br_grant(br_grant), .br_stall(br_stall),
  .res_ckpt_id(res_ckpt_id), .arch_clear(arch_clear),
  .restore_go(restore_go), .release_go(release_go), .write_go(write_go),
  .slot_live(slot_live)
);

// File: tb/rename_ckpt_table_test.sv
module rename_ckpt_table_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [3:0] src0_idx = '0, src1_idx = '0, dst_idx = '0;
  logic [4:0] dst_tag = '0;
  logic [1:0] res_ckpt_id = '0;
  logic dst_en = 0, br_req = 0, res_valid = 0, res_mispredict = 0, arch_clear = 0;
  logic src0_phys, src1_phys, br_grant, br_stall;
  logic [4:0] src0_tag, src1_tag;
  logic [1:0] br_ckpt_id;

  rename_ckpt_table uut (.*);

  // reference model: entry = -1 for architectural, else tag
  int m_map [16];
  int m_snap [4][16];
  bit m_live [4];
  int m_age [4];
  int m_seq;
  int checks, fails;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ent_val(input logic ph, input logic [4:0] tg);
    return ph ? int'(tg) : -1;
  endfunction

  // one cycle: compare outputs against model, then advance model at the edge
  task automatic step();
    bit hit, bad, good, gnt;
    int gid, rid;
    int nxt [16];
    rid = int'(res_ckpt_id);
    hit = m_live[rid];
    bad = res_valid && res_mispredict && hit && !arch_clear;
    good = res_valid && !res_mispredict && hit && !arch_clear;
    gid = -1;
    for (int s = 3; s >= 0; s--) if (!m_live[s]) gid = s;
    gnt = br_req && !arch_clear && !bad && (gid >= 0);
    #1;
    chk("R2/R12", "src0", ent_val(src0_phys, src0_tag), m_map[src0_idx]);
    chk("R2/R12", "src1", ent_val(src1_phys, src1_tag), m_map[src1_idx]);
    chk("R3/R4", "grant", int'(br_grant), int'(gnt));
    chk("R4", "stall", int'(br_stall), int'(br_req && !gnt));
    if (gnt) chk("R3", "ckpt_id", int'(br_ckpt_id), gid);
    @(posedge clk);
    if (arch_clear) begin
      for (int r = 0; r < 16; r++) m_map[r] = -1;
      for (int s = 0; s < 4; s++) m_live[s] = 0;
    end else if (bad) begin
      for (int r = 0; r < 16; r++) m_map[r] = m_snap[rid][r];
      for (int s = 0; s < 4; s++) if (m_live[s] && s != rid && m_age[s] > m_age[rid]) m_live[s] = 0;
      m_live[rid] = 0;
    end else begin
      if (good) m_live[rid] = 0;
      if (dst_en) m_map[dst_idx] = int'(dst_tag);
      if (gnt) begin
        for (int r = 0; r < 16; r++) m_snap[gid][r] = m_map[r];
        m_live[gid] = 1;
        m_age[gid] = m_seq++;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    dst_en = 0; br_req = 0; res_valid = 0; res_mispredict = 0; arch_clear = 0;
  endtask

  task automatic sweep();
    idle();
    for (int r = 0; r < 16; r += 2) begin
      src0_idx = 4'(r); src1_idx = 4'(r + 1);
      step();
    end
  endtask

  task automatic wr(input int r, input int t);
    idle(); dst_en = 1; dst_idx = 4'(r); dst_tag = 5'(t); step();
  endtask

  task automatic branch();
    idle(); br_req = 1; step();
  endtask

  task automatic resolve(input int id, input bit mis);
    idle(); res_valid = 1; res_mispredict = mis; res_ckpt_id = 2'(id); step();
  endtask

  initial begin
    automatic int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; fails = 0; m_seq = 0;
    for (int r = 0; r < 16; r++) m_map[r] = -1;
    for (int s = 0; s < 4; s++) begin m_live[s] = 0; m_age[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, all architectural, first grant is slot 0
    sweep();
    // R2: writes then lookups
    for (int r = 0; r < 16; r++) wr(r, r + 8);
    sweep();
    // R12: lookup in same cycle as write sees old value
    idle(); dst_en = 1; dst_idx = 4'd3; dst_tag = 5'd30; src0_idx = 4'd3; step();
    // R11: branch granted with same-cycle write includes it
    idle(); br_req = 1; dst_en = 1; dst_idx = 4'd5; dst_tag = 5'd1; step();
    wr(5, 2); wr(6, 3);
    branch();            // slot 1
    wr(7, 4);
    branch();            // slot 2
    wr(8, 5);
    branch();            // slot 3
    // R4: pool full
    branch(); branch();
    // R10: resolve a free slot is impossible here; free slot 2 correctly (R5)
    resolve(2, 0);
    sweep();
    resolve(2, 1);       // R10: slot 2 now free, ignored
    sweep();
    // R6/R7: mispredict slot 1, slot 3 younger freed, slot 0 kept
    wr(9, 6);
    resolve(1, 1);
    sweep();
    resolve(3, 1);       // R7: slot 3 was released, ignored
    sweep();
    // R8: restore in same cycle as write and branch request
    wr(10, 11);
    idle(); res_valid = 1; res_mispredict = 1; res_ckpt_id = 2'd0;
    br_req = 1; dst_en = 1; dst_idx = 4'd10; dst_tag = 5'd12; step();
    sweep();
    // R9: clear with everything else asserted
    branch(); branch(); wr(1, 9);
    idle(); arch_clear = 1; br_req = 1; dst_en = 1; res_valid = 1; res_mispredict = 1;
    res_ckpt_id = 2'd0; step();
    sweep();
    branch();
    // mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      automatic int k = int'($urandom_range(99));
      src0_idx = 4'($urandom_range(15)); src1_idx = 4'($urandom_range(15));
      dst_en = ($urandom_range(3) != 0); dst_idx = 4'($urandom_range(15));
      dst_tag = 5'($urandom_range(31));
      br_req = ($urandom_range(2) == 0);
      res_valid = (k < 30); res_mispredict = (k < 12);
      res_ckpt_id = 2'($urandom_range(3));
      arch_clear = (k == 99);
      step();
    end
    sweep();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule